// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block walks a video raster one dot at a time. Each cycle in which the dot enable is high moves a pixel position along the current line. At the end of the line the position returns to zero and a line counter steps forward. When the line counter reaches the programmed number of lines per field it returns to zero. In interlaced operation an odd/even field flag inverts at that point. A one-cycle frame strobe marks the moment the raster enters the line where retrace ends. That line is fixed at line 42 (0x2A).

Software programs the block through a small write port with four targets. The first is the geometry word, which holds lines per field and dots per line. The second is the sync-timing word, which holds the vertical sync line count and the horizontal sync width. The third is the sync-configuration word, which holds the interlace enable. The fourth is the front-porch word. A live 14-bit status word is always available. It combines the current line, the field flag, and sync and display-active flags. The flags are derived one way on lines whose parity equals the field flag and another way on lines of the opposite parity. All timing quantities are counted in dot clocks.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the geometry word is 0x0270035F (625 lines of 864 dots) and the sync-timing word is 0x07D6A53F (5 vsync lines, 128-dot hsync). Interlace is off and the front porch is 1 dot. The position is pixel 0, line 0, field 0, the status word reads 0 and the frame strobe is low.
- R2: The geometry write (select 0) keeps only bits 25:16 (lines per field minus one) and bits 9:0 (dots per line minus one). All other bits have no effect.
- R3: The line counter wraps from the last line of the field to line 0. The field flag inverts at that wrap only when bit 4 of the sync-configuration word (select 2) is set; no other bit of that word has any effect.
- R4: The frame strobe is high for exactly one cycle: the cycle right after the dot step that moves the line counter onto line 42. This happens again in every field whose line count exceeds 42.
- R5: The pixel position, the line counter and the field flag change only on cycles with the dot enable high. Register writes do not move them.
- R6: Status bits 9:0 hold the current line, and bit 10 holds the field flag (1 = odd).
- R7: On a line whose bit 0 equals the field flag, status bit 12 is set when the pixel position exceeds the hsync width. When the line is at or after the vsync line count, bit 13 is set. Bit 11 is also set when the pixel position exceeds the front-porch length. Status bits not named here are 0.
- R8: On a line whose bit 0 differs from the field flag, the behaviour depends on the vsync line count. At or after it, bits 13 and 12 are set, and bit 11 is also set while the pixel position plus the back-porch length is less than the line length. Before it, only bit 12 is set.
- R9: In the sync-timing word (select 1), bits 11:8 give the vsync line count. Bits 6:0 plus one, doubled, give the hsync width in dots. All other bits, including bit 7, have no effect.
- R10: In the front-porch word (select 3), bits 9:0 plus one give the front-porch length in dots. Upper bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_en | input | 1 | Dot-clock enable; one dot step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 geometry, 1 sync timing, 2 sync configuration, 3 front porch |
| wr_data | input | 32 | Write data |
| status_o | output | 14 | Live sync-status word |
| frame_o | output | 1 | One-cycle strobe on entering the retrace-end line |

## Verification
Three properties are checked on every cycle by assertions:
- The frame strobe only occurs at pixel 0 of line 42 and never on two cycles in a row.
- The position freezes when the dot enable is low, and the field flag changes only at a field wrap with interlace on.
- The active flag never appears without the vsync-off flag, and opposite-parity lines before the vsync count read only the hsync-off flag.

The exact positions of the sync, porch and active edges within a line can only be shown by the bench's sweeps, which compare every cycle against an arithmetic model. The same holds for the field sequence across several fields, for the discarding of masked-off register bits, and for the reset geometry.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int DOT_W     = 10;
    localparam int LINE_W    = 10;
    localparam int VS_W      = 4;
    localparam int HS_W      = 7;
    localparam int HSYNC_W   = HS_W + 2;
    localparam int LEN_W     = DOT_W + 1;
    localparam int STATUS_W  = 14;
    localparam int SEL_W     = 2;

    localparam logic [LINE_W-1:0] RETRACE_END_LINE = LINE_W'(42);

    localparam logic [31:0] GEOM_RESET = 32'h0270_035F;
    localparam logic [31:0] SYNC_RESET = 32'h07D6_A53F;

    typedef enum logic [SEL_W-1:0] {
        SEL_GEOM  = 2'd0,
        SEL_SYNC  = 2'd1,
        SEL_CFG   = 2'd2,
        SEL_PORCH = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [LINE_W-1:0] lines_m1;
        logic [DOT_W-1:0]  dots_m1;
        logic [VS_W-1:0]   vs_lines;
        logic [HS_W-1:0]   hs_code;
        logic              interlace;
        logic [DOT_W-1:0]  porch_code;
    } raster_cfg_t;

    typedef struct packed {
        logic [DOT_W-1:0]  pix;
        logic [LINE_W-1:0] line;
        logic              field;
    } raster_pos_t;

    function automatic logic [HSYNC_W-1:0] hsync_dots(input logic [HS_W-1:0] code);
        logic [HSYNC_W-1:0] plus1;
        plus1 = HSYNC_W'(code) + HSYNC_W'(1);
        return plus1 << 1;
    endfunction

    function automatic logic [LEN_W-1:0] porch_dots(input logic [DOT_W-1:0] code);
        return LEN_W'(code) + LEN_W'(1);
    endfunction

    function automatic logic [LEN_W-1:0] line_dots(input logic [DOT_W-1:0] dots_m1);
        return LEN_W'(dots_m1) + LEN_W'(1);
    endfunction

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [31:0]       wr_data,
    output raster_cfg_t       cfg_o
);

    raster_cfg_t cfg_q;
    reg_sel_e    sel;

    assign sel = reg_sel_e'(wr_sel);

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[31:26], wr_data[15:12], wr_data[10], wr_data[7]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.lines_m1   <= GEOM_RESET[16 +: LINE_W];
            cfg_q.dots_m1    <= GEOM_RESET[0 +: DOT_W];
            cfg_q.vs_lines   <= SYNC_RESET[8 +: VS_W];
            cfg_q.hs_code    <= SYNC_RESET[0 +: HS_W];
            cfg_q.interlace  <= 1'b0;
            cfg_q.porch_code <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_GEOM: begin
                    cfg_q.lines_m1 <= wr_data[16 +: LINE_W];
                    cfg_q.dots_m1  <= wr_data[0 +: DOT_W];
                end
                SEL_SYNC: begin
                    cfg_q.vs_lines <= wr_data[8 +: VS_W];
                    cfg_q.hs_code  <= wr_data[0 +: HS_W];
                end
                SEL_CFG:   cfg_q.interlace  <= wr_data[4];
                SEL_PORCH: cfg_q.porch_code <= wr_data[0 +: DOT_W];
                default: ;
            endcase
        end
    end

    assign cfg_o = cfg_q;

    // R1: reset loads the default geometry and sync timing
    a_r1_reset_defaults: assert property (@(posedge clk)
        rst |=> (cfg_o.lines_m1 == 10'h270 && cfg_o.dots_m1 == 10'h35F &&
                 cfg_o.vs_lines == 4'h5 && cfg_o.hs_code == 7'h3F &&
                 !cfg_o.interlace && cfg_o.porch_code == '0));

    // R5: configuration is stable when no write occurs
    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_o));

endmodule

// File: rtl/rtg_counter.sv
module rtg_counter
    import rtg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        dot_en,
    input  raster_cfg_t cfg,
    output raster_pos_t pos_o,
    output logic        frame_o
);

    raster_pos_t pos_q, pos_d;
    logic        frame_q, frame_d;
    logic        end_of_line;
    logic        end_of_field;

    assign end_of_line  = (pos_q.pix >= cfg.dots_m1);
    assign end_of_field = (pos_q.line >= cfg.lines_m1);

    always_comb begin
        pos_d   = pos_q;
        frame_d = 1'b0;
        if (dot_en) begin
            if (end_of_line) begin
                pos_d.pix = '0;
                if (end_of_field) begin
                    pos_d.line = '0;
                    if (cfg.interlace) begin
                        pos_d.field = ~pos_q.field;
                    end
                end else begin
                    pos_d.line = pos_q.line + LINE_W'(1);
                    frame_d    = (pos_d.line == RETRACE_END_LINE);
                end
            end else begin
                pos_d.pix = pos_q.pix + DOT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            frame_q <= 1'b0;
        end else begin
            pos_q   <= pos_d;
            frame_q <= frame_d;
        end
    end

    assign pos_o   = pos_q;
    assign frame_o = frame_q;

    // R4: the strobe marks pixel 0 of the retrace-end line
    a_r4_frame_at_retrace_end: assert property (@(posedge clk) disable iff (rst)
        frame_o |-> (pos_o.line == RETRACE_END_LINE && pos_o.pix == '0));

    // R4: the strobe lasts a single cycle
    a_r4_frame_single: assert property (@(posedge clk) disable iff (rst)
        frame_o |=> !frame_o);

    // R5: no movement without the dot enable
    a_r5_hold_position: assert property (@(posedge clk) disable iff (rst)
        !dot_en |=> $stable(pos_o));

    // R3: field flips only at a wrap with interlace on
    a_r3_field_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (pos_o.field != $past(pos_o.field)) |->
            (pos_o.line == '0 && pos_o.pix == '0 && $past(cfg.interlace)));

endmodule

// File: rtl/rtg_status.sv
module rtg_status
    import rtg_pkg::*;
#(
    parameter int BACK_PORCH_DOTS = 108
) (
    input  logic                clk,
    input  logic                rst,
    input  raster_cfg_t         cfg,
    input  raster_pos_t         pos,
    output logic [STATUS_W-1:0] status_o
);

    localparam int CMP_W = LEN_W + 8;

    logic               same_parity;
    logic               past_vsync;
    logic [HSYNC_W-1:0] hs_width;
    logic [LEN_W-1:0]   fp_len;
    logic [CMP_W-1:0]   pix_plus_bp;
    logic [CMP_W-1:0]   len_wide;
    logic               hsync_off;
    logic               vsync_off;
    logic               active;

    assign same_parity = (pos.line[0] == pos.field);
    assign past_vsync  = (pos.line >= LINE_W'(cfg.vs_lines));
    assign hs_width    = hsync_dots(cfg.hs_code);
    assign fp_len      = porch_dots(cfg.porch_code);
    assign pix_plus_bp = CMP_W'(pos.pix) + CMP_W'(BACK_PORCH_DOTS);
    assign len_wide    = CMP_W'(line_dots(cfg.dots_m1));

    always_comb begin
        hsync_off = 1'b0;
        vsync_off = 1'b0;
        active    = 1'b0;
        if (same_parity) begin
            hsync_off = (HSYNC_W'(pos.pix) > hs_width) || (pos.pix[DOT_W-1:HSYNC_W] != '0);
            if (past_vsync) begin
                vsync_off = 1'b1;
                active    = (LEN_W'(pos.pix) > fp_len);
            end
        end else begin
            hsync_off = 1'b1;
            if (past_vsync) begin
                vsync_off = 1'b1;
                active    = (pix_plus_bp < len_wide);
            end
        end
    end

    assign status_o = {vsync_off, hsync_off, active, pos.field, pos.line};

    // R7: the active flag never appears during vertical sync
    a_r7_active_needs_vsync_off: assert property (@(posedge clk) disable iff (rst)
        status_o[11] |-> status_o[13]);

    // R8: opposite-parity lines before the vsync count show only hsync-off
    a_r8_early_other_parity: assert property (@(posedge clk) disable iff (rst)
        (pos.line[0] != pos.field && pos.line < LINE_W'(cfg.vs_lines)) |->
            (status_o[13:11] == 3'b010));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int BACK_PORCH_DOTS = 108
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dot_en,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [31:0]          wr_data,
    output logic [STATUS_W-1:0]  status_o,
    output logic                 frame_o
);

    raster_cfg_t cfg;
    raster_pos_t pos;

    rtg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg_o   (cfg)
    );

    rtg_counter u_counter (
        .clk     (clk),
        .rst     (rst),
        .dot_en  (dot_en),
        .cfg     (cfg),
        .pos_o   (pos),
        .frame_o (frame_o)
    );

    rtg_status #(
        .BACK_PORCH_DOTS (BACK_PORCH_DOTS)
    ) u_status (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .pos      (pos),
        .status_o (status_o)
    );

endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

    localparam int BP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dot_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [13:0] status_o;
    logic        frame_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_len, m_lines, m_vs, m_hs, m_fp, m_il;

    raster_timing_gen #(.BACK_PORCH_DOTS(BP)) u_raster_timing_gen (
        .clk      (clk),
        .rst      (rst),
        .dot_en   (dot_en),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .status_o (status_o),
        .frame_o  (frame_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_status(input int pix, input int line, input int fld);
        int s;
        s = line | (fld << 10);
        if ((line & 1) == fld) begin
            if (pix > m_hs) s |= 32'h1000;
            if (line >= m_vs) s |= (pix > m_fp) ? 32'h2800 : 32'h2000;
        end else begin
            if (line >= m_vs) s |= (pix + BP < m_len) ? 32'h3800 : 32'h3000;
            else              s |= 32'h1000;
        end
        return s;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; dot_en = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Sweep: gap_mod 0 means enable every cycle, else skip every gap_mod-th cycle
    task automatic sweep(input string tag, input int cycles, input int gap_mod);
        int n;
        bit last_en;
        n = 0;
        last_en = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            begin
                int pix, la, line, fld, expf;
                pix  = n % m_len;
                la   = n / m_len;
                line = la % m_lines;
                fld  = m_il ? ((la / m_lines) & 1) : 0;
                expf = (last_en && pix == 0 && line == 42) ? 1 : 0;
                check({tag, " R6 line/field"}, int'(status_o[10:0]), line | (fld << 10));
                check(((line & 1) == fld) ? {tag, " R7 flags"} : {tag, " R8 flags"},
                      int'(status_o), model_status(pix, line, fld));
                check({tag, " R4 frame"}, int'(frame_o), expf);
            end
            dot_en  = (gap_mod == 0) ? 1'b1 : ((i % gap_mod) != 0);
            last_en = dot_en;
            if (dot_en) n++;
        end
        @(negedge clk);
        dot_en = 1'b0;
    endtask

    initial begin
        // R1: reset state and default geometry/sync
        do_reset();
        check("R1 status after reset", int'(status_o), 0);
        check("R1 frame after reset", int'(frame_o), 0);
        m_len = 864; m_lines = 625; m_vs = 5; m_hs = 128; m_fp = 1; m_il = 0;
        sweep("R1 default", 870, 0);

        // R2 R9 R10: masked writes, non-interlaced, continuous dots (R5 writes do not move)
        do_reset();
        wr(2'd0, 32'hFC31_FC0B);
        wr(2'd1, 32'hFFFF_F283);
        wr(2'd3, 32'hFFFF_FC05);
        m_len = 12; m_lines = 50; m_vs = 2; m_hs = 8; m_fp = 6; m_il = 0;
        sweep("R2 R9 R10 R3 progressive", 1300, 0);

        // R3 R5: interlace on, gapped dot enable, three fields
        do_reset();
        wr(2'd0, 32'h0031_000B);
        wr(2'd1, 32'h0000_0203);
        wr(2'd3, 32'h0000_0005);
        wr(2'd2, 32'h0000_0010);
        m_il = 1;
        sweep("R3 R5 interlaced", 2750, 3);

        // R3: every sync-config bit except bit 4 has no effect
        do_reset();
        wr(2'd0, 32'h0031_000B);
        wr(2'd1, 32'h0000_0203);
        wr(2'd3, 32'h0000_0005);
        wr(2'd2, 32'hFFFF_FFEF);
        m_il = 0;
        sweep("R3 config bits", 1300, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule